// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Sequencer

This block runs single-word accesses to an external asynchronous SRAM or NOR flash. A host raises a request with a direction, an address, write data and byte-lane enables. The block then drives the external address bus, the chip-select, output-enable and write-enable strobes and, for writes, the data bus. It returns read data together with a one-cycle completion pulse. All strobes are active-low and rest high.

The timing of each strobe edge comes from a small bank of timing fields, which are written through a narrow configuration port. The external bus can be 8 or 16 bits wide. Every offset is counted in clock cycles from the cycle in which chip-select first goes low (cycle 0). Each edge follows its own rule. Output-enable falls after n cycles. Write-enable falls after n+1 cycles. A read occupies n+1 cycles. Write-enable rises after n+2 cycles. The fields are copied when a request is accepted, so a configuration write made during an access applies to the next access.

Top module: `asram_strobe_ctl`

## Requirements
- R1: After reset, all strobes and byte enables are high, the data bus is not driven, done is low and ready is high. The field reset values are bus width 0, write-enable delay 0, output-enable delay 0, read cycle 31 and write cycle 31.
- R2: For a read, chip-select stays low for exactly max(rd, oe)+1 consecutive cycles. Here rd is the read-cycle field and oe is the output-enable delay field.
- R3: For a read, output-enable first goes low in cycle oe, which is cycle 0 when oe is 0. It stays low and rises together with chip-select.
- R4: Read data is sampled from the external bus in the last chip-select-low cycle. It is presented on rdata_o in the cycle after chip-select rises, together with a done pulse one cycle long.
- R5: For a write, write-enable first goes low in cycle we+1, where we is the write-enable delay field.
- R6: For a write, write-enable is high again in cycle max(wr, we)+2, where wr is the write-cycle field. Write-enable is therefore low for at least one cycle even when we is not less than wr.
- R7: For a write, the data bus is driven from cycle 0 through the cycle in which write-enable rises. Chip-select stays low through that same cycle. Both are released one cycle later, and done is pulsed in that cycle.
- R8: Configuration address 0 holds the bus width. Code 01 selects 16 bits: the full data word is used, mem_be_no is the inverse of the request's byte enables, and rdata_o carries all 16 bits. Every other code, including the reserved codes 10 and 11, selects 8 bits: only bits 7:0 carry data, bits 15:8 of mem_dq_o and rdata_o are zero, and mem_be_no is 2'b10 while chip-select is low.
- R9: The read-cycle and write-cycle code 31 is taken as 31. A read then lasts 32 cycles, and a write-enable pulse then ends in cycle 33.
- R10: A request is accepted only when ready is high, that is, in idle after the completion cycle. A request raised during an access or during its completion cycle starts nothing.
- R11: Configuration addresses 1 to 4 hold the write-enable delay, output-enable delay, read-cycle and write-cycle fields. A configuration write during an access does not change that access, and it applies from the next accepted request.
- R12: Output-enable and write-enable are never low together, and neither is low while chip-select is high. Address and byte enables hold steady while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_addr_i | input | 3 | configuration field select |
| cfg_wdata_i | input | CFG_W | configuration write value |
| req_valid_i | input | 1 | access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | access address |
| req_wdata_i | input | DW | write data |
| req_be_i | input | 2 | byte-lane enables, active high |
| req_ready_o | output | 1 | block idle, request will be accepted |
| done_o | output | 1 | access complete pulse |
| rdata_o | output | DW | read data |
| mem_addr_o | output | AW | external address |
| mem_dq_o | output | DW | external write data |
| mem_dq_oe_o | output | 1 | external data bus drive enable |
| mem_dq_i | input | DW | external read data |
| mem_cs_no | output | 1 | chip select, active low |
| mem_oe_no | output | 1 | output enable, active low |
| mem_we_no | output | 1 | write enable, active low |
| mem_be_no | output | 2 | byte-lane enables, active low |

## Verification
A wrong phase counter or a bad end-of-access value shows up within the same access. A strobe edge then moves by a whole number of cycles against the arithmetic expectation, or a read returns the bus pattern of a neighbouring cycle, because the bench changes the bus value every cycle. A wrong snapshot of the timing fields first shows up in the access after a configuration write. A wrong return to idle shows up at the next request, either as ready held low or as an extra chip-select pulse. The sweep covers every read-cycle and output-enable pair, every write-cycle and write-enable pair, and all four bus-width codes, so each edge rule is exercised at both ends of its range.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_GAP} st_e;

  localparam logic [2:0] CFG_BW = 3'd0;
  localparam logic [2:0] CFG_WE = 3'd1;
  localparam logic [2:0] CFG_OE = 3'd2;
  localparam logic [2:0] CFG_RD = 3'd3;
  localparam logic [2:0] CFG_WR = 3'd4;

  localparam logic [1:0] BW_16 = 2'b01;
endpackage

// File: rtl/asram_cfg_regs.sv
module asram_cfg_regs import asram_pkg::*; #(
  parameter int WE_W  = 4,
  parameter int OE_W  = 4,
  parameter int CYC_W = 5,
  parameter int CFG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [1:0]       bw_o,
  output logic [WE_W-1:0]  we_dly_o,
  output logic [OE_W-1:0]  oe_dly_o,
  output logic [CYC_W-1:0] rd_cyc_o,
  output logic [CYC_W-1:0] wr_cyc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bw_o     <= '0;
      we_dly_o <= '0;
      oe_dly_o <= '0;
      rd_cyc_o <= '1;
      wr_cyc_o <= '1;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        CFG_BW:  bw_o     <= cfg_wdata_i[1:0];
        CFG_WE:  we_dly_o <= cfg_wdata_i[WE_W-1:0];
        CFG_OE:  oe_dly_o <= cfg_wdata_i[OE_W-1:0];
        CFG_RD:  rd_cyc_o <= cfg_wdata_i[CYC_W-1:0];
        CFG_WR:  wr_cyc_o <= cfg_wdata_i[CYC_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/asram_seq.sv
module asram_seq import asram_pkg::*; #(
  parameter int WE_W  = 4,
  parameter int OE_W  = 4,
  parameter int CYC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [WE_W-1:0]  we_dly_i,
  input  logic [OE_W-1:0]  oe_dly_i,
  input  logic [CYC_W-1:0] rd_cyc_i,
  input  logic [CYC_W-1:0] wr_cyc_i,
  output logic             accept_o,
  output logic             ready_o,
  output logic             cs_act_o,
  output logic             oe_act_o,
  output logic             we_act_o,
  output logic             dq_oe_o,
  output logic             sample_o,
  output logic             done_o
);
  localparam int MAX_A = (WE_W > OE_W) ? WE_W : OE_W;
  localparam int MAX_W = (CYC_W > MAX_A) ? CYC_W : MAX_A;
  localparam int CNT_W = MAX_W + 1;
  typedef logic [CNT_W-1:0] cnt_t;

  st_e  st_q;
  cnt_t cnt_q, end_q, on_q;
  logic wr_q;
  cnt_t we_x, oe_x, rd_x, wr_x, rd_end, wr_end, end_d, on_d;
  logic last, strb;

  // read end stretched so OE sees at least the last cycle
  always_comb begin
    we_x   = cnt_t'(we_dly_i);
    oe_x   = cnt_t'(oe_dly_i);
    rd_x   = cnt_t'(rd_cyc_i);
    wr_x   = cnt_t'(wr_cyc_i);
    rd_end = (rd_x > oe_x) ? rd_x : oe_x;
    wr_end = ((wr_x > we_x) ? wr_x : we_x) + cnt_t'(2);
    end_d  = req_write_i ? wr_end : rd_end;
    on_d   = req_write_i ? we_x + cnt_t'(1) : oe_x;
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;
  assign cs_act_o = (st_q == ST_ACC);
  assign last     = cs_act_o && (cnt_q == end_q);
  assign strb     = cs_act_o && (cnt_q >= on_q) && (!wr_q || (cnt_q < end_q));
  assign oe_act_o = strb && !wr_q;
  assign we_act_o = strb && wr_q;
  assign dq_oe_o  = cs_act_o && wr_q;
  assign sample_o = last && !wr_q;
  assign done_o   = (st_q == ST_GAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      end_q <= '0;
      on_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_o) begin
          st_q  <= ST_ACC;
          cnt_q <= '0;
          end_q <= end_d;
          on_q  <= on_d;
          wr_q  <= req_write_i;
        end
        ST_ACC: begin
          if (last) st_q <= ST_GAP;
          else      cnt_q <= cnt_q + cnt_t'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_lane.sv
module asram_lane import asram_pkg::*; #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_be_i,
  input  logic [1:0]    bw_i,
  input  logic          cs_act_i,
  input  logic          sample_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic [1:0]    mem_be_no,
  output logic [DW-1:0] rdata_o
);
  localparam int LW = DW / 2;

  logic [DW-1:0] wdata_q;
  logic [1:0]    be_q;
  logic          wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      wide_q     <= 1'b0;
    end else if (accept_i) begin
      mem_addr_o <= req_addr_i;
      wdata_q    <= req_wdata_i;
      be_q       <= req_be_i;
      wide_q     <= (bw_i == BW_16);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (sample_i) rdata_o <= wide_q ? mem_dq_i : {{(DW-LW){1'b0}}, mem_dq_i[LW-1:0]};
  end

  assign mem_dq_o  = wide_q ? wdata_q : {{(DW-LW){1'b0}}, wdata_q[LW-1:0]};
  assign mem_be_no = !cs_act_i ? 2'b11 : (wide_q ? ~be_q : 2'b10);
endmodule

// File: rtl/asram_strobe_ctl.sv
module asram_strobe_ctl import asram_pkg::*; #(
  parameter int AW    = 20,
  parameter int DW    = 16,
  parameter int WE_W  = 4,
  parameter int OE_W  = 4,
  parameter int CYC_W = 5,
  parameter int CFG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [1:0]       req_be_i,
  output logic             req_ready_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe_o,
  input  logic [DW-1:0]    mem_dq_i,
  output logic             mem_cs_no,
  output logic             mem_oe_no,
  output logic             mem_we_no,
  output logic [1:0]       mem_be_no
);
  logic [1:0]       bw;
  logic [WE_W-1:0]  we_dly;
  logic [OE_W-1:0]  oe_dly;
  logic [CYC_W-1:0] rd_cyc, wr_cyc;
  logic             accept, cs_act, oe_act, we_act, sample;

  asram_cfg_regs #(.WE_W(WE_W), .OE_W(OE_W), .CYC_W(CYC_W), .CFG_W(CFG_W)) i_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .bw_o(bw), .we_dly_o(we_dly), .oe_dly_o(oe_dly), .rd_cyc_o(rd_cyc), .wr_cyc_o(wr_cyc)
  );

  asram_seq #(.WE_W(WE_W), .OE_W(OE_W), .CYC_W(CYC_W)) i_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i,
    .we_dly_i(we_dly), .oe_dly_i(oe_dly), .rd_cyc_i(rd_cyc), .wr_cyc_i(wr_cyc),
    .accept_o(accept), .ready_o(req_ready_o), .cs_act_o(cs_act), .oe_act_o(oe_act),
    .we_act_o(we_act), .dq_oe_o(mem_dq_oe_o), .sample_o(sample), .done_o(done_o)
  );

  asram_lane #(.AW(AW), .DW(DW)) i_lane (
    .clk_i, .rst_ni, .accept_i(accept), .req_addr_i, .req_wdata_i, .req_be_i,
    .bw_i(bw), .cs_act_i(cs_act), .sample_i(sample), .mem_dq_i,
    .mem_addr_o, .mem_dq_o, .mem_be_no, .rdata_o
  );

  assign mem_cs_no = ~cs_act;
  assign mem_oe_no = ~oe_act;
  assign mem_we_no = ~we_act;
endmodule

// File: rtl/asram_strobe_chk.sv
module asram_strobe_chk #(
  parameter int AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          done_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_dq_oe_o,
  input logic          mem_cs_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic [1:0]    mem_be_no
);
  // R12
  idle_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_no |-> (mem_oe_no && mem_we_no && mem_be_no == 2'b11));
  // R12
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  // R12
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> ($stable(mem_addr_o) && $stable(mem_be_no)));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_no) |-> done_o);
  // R7
  dq_under_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> !mem_cs_no);
  // R7
  we_rise_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> !mem_cs_no);
  // R10
  start_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_cs_no) |-> $past(req_ready_o && req_valid_i));
  // R10
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_no && !done_o));
endmodule

bind asram_strobe_ctl asram_strobe_chk #(.AW(AW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_cs_no(mem_cs_no),
  .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no), .mem_be_no(mem_be_no)
);

// File: tb/test_asram_strobe_ctl.sv
`timescale 1ns/1ps
module test_asram_strobe_ctl;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [4:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0; logic [1:0] req_be = 0;
  logic req_ready, done, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;
  logic [DW-1:0] rdata, mem_dq_o, mem_dq_i = 0;
  logic [AW-1:0] mem_addr; logic [1:0] mem_be_n;

  always #4 clk = ~clk;

  asram_strobe_ctl i_asram_strobe_ctl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .req_ready_o(req_ready), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_cs_no(mem_cs_n), .mem_oe_no(mem_oe_n), .mem_we_no(mem_we_n), .mem_be_no(mem_be_n)
  );

  int total = 0, bad = 0;
  int cs_n, cs_first, cs_last, oe_n, oe_first, oe_last, we_n, we_first, we_last;
  int dq_first, dq_last, done_n, done_t, lane_ok, addr_ok, rdy_at_done, rdy_after, extra_cs;
  logic [DW-1:0] got_rdata;
  bit wide;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int t);
    return {8'(8'hC0 + t), 8'(8'h3C ^ (t * 7))};
  endfunction

  task automatic cfg(input logic [2:0] a, input int v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = 5'(v);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [1:0] be, input bit mid, input logic [2:0] mid_a,
                        input int mid_v, input bit rogue);
    int t;
    bit fin;
    logic [DW-1:0] exp_dq;
    logic [1:0] exp_be;
    cs_n = 0; cs_first = -1; cs_last = -1; oe_n = 0; oe_first = -1; oe_last = -1;
    we_n = 0; we_first = -1; we_last = -1; dq_first = -1; dq_last = -1;
    done_n = 0; done_t = -1; lane_ok = 1; addr_ok = 1; extra_cs = 0;
    exp_dq = wide ? wd : {8'h00, wd[7:0]};
    exp_be = wide ? ~be : 2'b10;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_be = ~be;
    t = 0; fin = 0;
    while (!fin && t < 90) begin
      mem_dq_i = pat(t);
      cfg_we = (mid && t == 1);
      cfg_addr = mid_a; cfg_wdata = 5'(mid_v);
      if (rogue) begin req_valid = (t >= 1 && t <= 3); req_write = ~wr; end
      if (!mem_cs_n) begin
        cs_n++; if (cs_first < 0) cs_first = t; cs_last = t;
        if (mem_addr != a) addr_ok = 0;
        if (mem_be_n != exp_be) lane_ok = 0;
      end
      if (!mem_oe_n) begin oe_n++; if (oe_first < 0) oe_first = t; oe_last = t; end
      if (!mem_we_n) begin we_n++; if (we_first < 0) we_first = t; we_last = t; end
      if (mem_dq_oe) begin
        if (dq_first < 0) dq_first = t; dq_last = t;
        if (mem_dq_o != exp_dq) lane_ok = 0;
      end
      if (done) begin
        done_n++; done_t = t; got_rdata = rdata; rdy_at_done = int'(req_ready); fin = 1;
      end
      @(negedge clk);
      t++;
    end
    req_valid = 0; cfg_we = 0;
    rdy_after = int'(req_ready);
    for (int k = 0; k < 3; k++) begin
      if (!mem_cs_n) extra_cs++;
      @(negedge clk);
    end
  endtask

  task automatic check_read(input int rd, input int oe, input int e_override);
    int e;
    logic [DW-1:0] er;
    e = (e_override >= 0) ? e_override : ((rd > oe) ? rd : oe);
    er = wide ? pat(e) : {8'h00, pat(e)[7:0]};
    chk(cs_first == 0 && cs_last == e && cs_n == e + 1, "R2 cs low cycles", cs_n, e + 1);
    chk(oe_first == (e_override >= 0 ? oe_first : oe), "R3 oe fall cycle", oe_first, oe);
    chk(oe_last == e && oe_n == e - oe_first + 1, "R3 oe release", oe_last, e);
    chk(we_n == 0 && dq_first < 0, "R12 no we/dq on read", we_n, 0);
    chk(done_t == e + 1 && done_n == 1, "R4 done cycle", done_t, e + 1);
    chk(got_rdata == er, "R4 R8 read data", int'(got_rdata), int'(er));
    chk(addr_ok == 1 && lane_ok == 1, "R8 R12 addr/lanes", addr_ok + lane_ok, 2);
    chk(rdy_at_done == 0 && rdy_after == 1, "R10 ready", rdy_at_done * 2 + rdy_after, 1);
  endtask

  task automatic check_write(input int wr, input int we);
    int r;
    r = ((wr > we) ? wr : we) + 2;
    chk(cs_first == 0 && cs_last == r && cs_n == r + 1, "R7 cs low cycles", cs_n, r + 1);
    chk(we_first == we + 1, "R5 we fall cycle", we_first, we + 1);
    chk(we_last == r - 1 && we_n == r - we - 1, "R6 we rise cycle", we_last + 1, r);
    chk(oe_n == 0, "R12 no oe on write", oe_n, 0);
    chk(dq_first == 0 && dq_last == r, "R7 data drive span", dq_last, r);
    chk(done_t == r + 1 && done_n == 1, "R7 done cycle", done_t, r + 1);
    chk(addr_ok == 1 && lane_ok == 1, "R8 R12 addr/lanes", addr_ok + lane_ok, 2);
    chk(rdy_at_done == 0 && rdy_after == 1, "R10 ready", rdy_at_done * 2 + rdy_after, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe && !done,
        "R1 reset outputs", 0, 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !done, "R1 after release", int'(req_ready), 1);
    // R1 R9 default fields: 8-bit bus, rd=31 oe=0 / wr=31 we=0
    wide = 0;
    access(0, 20'h12345, 16'h0, 2'b11, 0, 0, 0, 0);
    check_read(31, 0, -1);
    access(1, 20'h00abc, 16'hbeef, 2'b11, 0, 0, 0, 0);
    check_write(31, 0);
    // R2 R3 R4 R8 sweep of all rd/oe pairs and bus width codes
    for (int rd = 0; rd < 32; rd++) begin
      for (int oe = 0; oe < 16; oe++) begin
        cfg(3'd0, (rd + oe) % 4);
        cfg(3'd2, oe);
        cfg(3'd3, rd);
        wide = (((rd + oe) % 4) == 1);
        access(0, AW'(rd * 64 + oe), 16'h0, 2'(rd), 0, 0, 0, 0);
        check_read(rd, oe, -1);
      end
    end
    // R5 R6 R7 R8 sweep of all wr/we pairs
    for (int wr = 0; wr < 32; wr++) begin
      for (int we = 0; we < 16; we++) begin
        cfg(3'd0, (wr + we) % 4);
        cfg(3'd1, we);
        cfg(3'd4, wr);
        wide = (((wr + we) % 4) == 1);
        access(1, AW'(wr * 97 + we), 16'(wr * 1031 + we * 17 + 16'h8001), 2'(we + 1), 0, 0, 0, 0);
        check_write(wr, we);
      end
    end
    // R11 mid-access config write does not alter current access
    cfg(3'd0, 1); wide = 1;
    cfg(3'd2, 1); cfg(3'd3, 3);
    access(0, 20'h55555, 16'h0, 2'b01, 1, 3'd3, 10, 0);
    check_read(3, 1, 3);
    chk(cs_n == 4, "R11 current read unchanged", cs_n, 4);
    access(0, 20'h55556, 16'h0, 2'b10, 0, 0, 0, 0);
    chk(cs_n == 11, "R11 new read length applied", cs_n, 11);
    cfg(3'd1, 2); cfg(3'd4, 4);
    access(1, 20'h0f0f0, 16'h1234, 2'b11, 1, 3'd1, 9, 0);
    check_write(4, 2);
    access(1, 20'h0f0f1, 16'h4321, 2'b11, 0, 0, 0, 0);
    chk(we_first == 10, "R11 new we delay applied", we_first, 10);
    // R10 requests during an access are ignored
    cfg(3'd3, 6); cfg(3'd2, 0);
    access(0, 20'h0aaaa, 16'h0, 2'b11, 0, 0, 0, 1);
    check_read(6, 0, -1);
    chk(extra_cs == 0, "R10 no extra access", extra_cs, 0);
    // R10 idle with no request leaves strobes high
    chk(mem_cs_n && req_ready, "R10 idle", int'(mem_cs_n), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule